// File: doc/BRIEF.md
# TDM Slave Audio Receiver

This block recovers audio words from a time-division-multiplexed serial stream. It runs as a slave: the serial bit clock and the frame marker both come from an external master. The block runs directly on the serial bit clock, so serial data and frame marker are both sampled on its rising edge. A frame begins at a low-to-high transition of the frame marker. The marker's width carries no meaning, and the marker may stay high for as little as one bit period or for most of the frame. The first data bit follows one bit period after the transition.

Each frame carries a parameterized number of channel slots, each sent MSB first. A slot is either 32 bits long, holding a 24-bit sample followed by eight pad bits that are thrown away, or 16 bits long, holding a 16-bit sample. The slot format is taken from a select input at the start of each frame. Each finished sample appears on a 24-bit output with a one-cycle strobe and its channel number. If a new frame starts before the last slot has ended, the block restarts at the new frame and flags a framing error.

Because the data lags the marker by one bit, the final bit of the last slot is sampled on the same edge that sees the next frame's marker rise. That bit is still taken as part of the ending frame.

Top module: `tdm_rx`

## Requirements
- R1: While reset is held and after it is released, `word_valid` and `frame_err` are 0 until a frame has been received.
- R2: A frame starts on the clock edge where `fsync` is sampled 1 after having been sampled 0. The first bit of channel 0 is sampled on the next edge. The width of the high phase of `fsync` has no effect.
- R3: With `slot16` = 0 at frame start, each slot is 32 bits. Its first 24 bits, MSB first, appear as `word_data[23:0]`. The following 8 pad bits never affect `word_data`.
- R4: With `slot16` = 1 at frame start, each slot is 16 bits. The 16-bit sample appears MSB-aligned as `word_data[23:8]`, with `word_data[7:0]` = 0.
- R5: `word_valid` is high for exactly one cycle, visible right after the edge that sampled the last audio bit of a slot. `word_chan` gives the slot index, counting 0 to CHANNELS-1 in arrival order.
- R6: After the last configured slot of a frame, further bits produce no word until the next `fsync` rising edge.
- R7: When the next frame's `fsync` rise is sampled on the same edge as the final bit of the last slot, that bit is captured into the ending frame's word. No framing error is raised.
- R8: An `fsync` rise that arrives before the final bit of the last slot makes `frame_err` high for one cycle, right after that edge. The block produces no word for the unfinished slot and restarts at channel 0.
- R9: `slot16` is sampled only on the frame-start edge. Changing it inside a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock from the external master |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame marker; a rising edge starts a frame |
| sdata | input | 1 | Serial audio data, MSB first |
| slot16 | input | 1 | Slot format select: 1 = 16-bit slots, 0 = 32-bit slots with 24-bit audio |
| word_valid | output | 1 | One-cycle strobe for a completed audio word |
| word_data | output | 24 | Completed audio word, MSB-aligned |
| word_chan | output | max(1, clog2(CHANNELS)) | Channel index of the completed word |
| frame_err | output | 1 | One-cycle pulse when a frame restarts early |

## Verification
The checker watches several properties on every cycle:
- the strobe and the error flag are always single-cycle pulses;
- an error appears only directly after a sampled marker rise;
- no word completes on the bit right after a frame start;
- the low byte is zero in 16-bit frames.

Only the bench scenarios can show the remaining behaviour:
- bit-exact word contents;
- channel ordering;
- pad and idle bits being discarded;
- the overlapped final bit being captured;
- a mid-frame change of `slot16` being ignored.

For these, the bench computes every sampled bit and every expected word arithmetically.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
    localparam int unsigned WORD_W      = 24;
    localparam int unsigned LONG_SLOT   = 32;
    localparam int unsigned LONG_AUDIO  = 24;
    localparam int unsigned SHORT_SLOT  = 16;
    localparam int unsigned SHORT_AUDIO = 16;
    localparam int unsigned BIT_W       = $clog2(LONG_SLOT);

    typedef logic [BIT_W-1:0] bitpos_t;
endpackage

// File: rtl/tdm_rx_edge.sv
module tdm_rx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = fsync;
        rise      = fsync & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/tdm_rx_seq.sv
module tdm_rx_seq
    import tdm_rx_pkg::*;
#(
    parameter int unsigned CHANNELS = 4,
    parameter int unsigned CH_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rise,
    input  logic            slot16,
    output logic            capture,
    output logic            done,
    output logic [CH_W-1:0] chan,
    output logic            mode16,
    output logic            frame_err
);
    localparam logic [CH_W-1:0] LAST_SLOT = CH_W'(CHANNELS - 1);

    typedef struct packed {
        logic            active;
        logic            mode16;
        bitpos_t         bpos;
        logic [CH_W-1:0] slot;
        logic            err;
    } seq_t;

    seq_t    st_d, st_q;
    bitpos_t slot_end;
    bitpos_t audio_end;
    logic    frame_end;

    always_comb begin
        slot_end  = st_q.mode16 ? bitpos_t'(SHORT_SLOT - 1)  : bitpos_t'(LONG_SLOT - 1);
        audio_end = st_q.mode16 ? bitpos_t'(SHORT_AUDIO - 1) : bitpos_t'(LONG_AUDIO - 1);
        frame_end = st_q.active && (st_q.bpos == slot_end) && (st_q.slot == LAST_SLOT);
        capture   = st_q.active && (st_q.bpos <= audio_end);
        done      = st_q.active && (st_q.bpos == audio_end);

        st_d     = st_q;
        st_d.err = 1'b0;
        if (rise) begin
            st_d.active = 1'b1;
            st_d.mode16 = slot16;
            st_d.bpos   = '0;
            st_d.slot   = '0;
            st_d.err    = st_q.active && !frame_end;
        end else if (st_q.active) begin
            if (st_q.bpos == slot_end) begin
                st_d.bpos = '0;
                if (st_q.slot == LAST_SLOT) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.slot = st_q.slot + CH_W'(1);
                end
            end else begin
                st_d.bpos = st_q.bpos + bitpos_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chan      = st_q.slot;
    assign mode16    = st_q.mode16;
    assign frame_err = st_q.err;
endmodule

// File: rtl/tdm_rx_shift.sv
module tdm_rx_shift
    import tdm_rx_pkg::*;
#(
    parameter int unsigned CH_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic              capture,
    input  logic              done,
    input  logic              mode16,
    input  logic [CH_W-1:0]   chan,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic [CH_W-1:0]   word_chan
);
    localparam int unsigned PAD_W = WORD_W - SHORT_AUDIO;

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic              valid;
        logic [WORD_W-1:0] data;
        logic [CH_W-1:0]   chan;
    } shf_t;

    shf_t              st_d, st_q;
    logic [WORD_W-1:0] nxt;

    always_comb begin
        nxt        = {st_q.sh[WORD_W-2:0], sdata};
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (capture) begin
            st_d.sh = nxt;
        end
        if (done) begin
            st_d.valid = 1'b1;
            st_d.chan  = chan;
            st_d.data  = mode16 ? {nxt[SHORT_AUDIO-1:0], {PAD_W{1'b0}}} : nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_valid = st_q.valid;
    assign word_data  = st_q.data;
    assign word_chan  = st_q.chan;
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
    import tdm_rx_pkg::*;
#(
    parameter  int unsigned CHANNELS = 4,
    localparam int unsigned CH_W     = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              sdata,
    input  logic              slot16,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic [CH_W-1:0]   word_chan,
    output logic              frame_err
);
    logic            rise_w;
    logic            capture_w;
    logic            done_w;
    logic            mode16_w;
    logic [CH_W-1:0] chan_w;

    tdm_rx_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .fsync (fsync),
        .rise  (rise_w)
    );

    tdm_rx_seq #(
        .CHANNELS (CHANNELS),
        .CH_W     (CH_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise_w),
        .slot16    (slot16),
        .capture   (capture_w),
        .done      (done_w),
        .chan      (chan_w),
        .mode16    (mode16_w),
        .frame_err (frame_err)
    );

    tdm_rx_shift #(
        .CH_W (CH_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sdata      (sdata),
        .capture    (capture_w),
        .done       (done_w),
        .mode16     (mode16_w),
        .chan       (chan_w),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_chan  (word_chan)
    );
endmodule

// File: rtl/tdm_rx_chk.sv
module tdm_rx_chk #(
    parameter int unsigned CHANNELS = 4,
    parameter int unsigned CH_W     = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fsync,
    input logic            frame_is16,
    input logic            word_valid,
    input logic [23:0]     word_data,
    input logic [CH_W-1:0] word_chan,
    input logic            frame_err
);
    logic rst_seen;

    always_ff @(posedge clk) begin
        rst_seen <= !rst_n;
    end

    always @(negedge clk) begin
        if (!rst_n && rst_seen === 1'b1) begin
            assert_reset_quiet_R1: assert (!word_valid && !frame_err)
                else $error("outputs active during reset");
        end
    end

    assert_first_bit_no_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsync, 2) && !$past(fsync, 3)) |-> !word_valid);

    assert_short_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && frame_is16) |-> (word_data[7:0] == 8'h00));

    assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    assert_err_after_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> ($past(fsync) && !$past(fsync, 2)));
endmodule

bind tdm_rx tdm_rx_chk #(
    .CHANNELS (CHANNELS),
    .CH_W     (CH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fsync      (fsync),
    .frame_is16 (mode16_w),
    .word_valid (word_valid),
    .word_data  (word_data),
    .word_chan  (word_chan),
    .frame_err  (frame_err)
);

// File: tb/sim_tdm_rx.sv
`timescale 1ns/1ps
module sim_tdm_rx;
    localparam int NCH  = 4;
    localparam int CH_W = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fsync = 1'b0;
    logic            sdata = 1'b0;
    logic            slot16 = 1'b0;
    logic            word_valid;
    logic [23:0]     word_data;
    logic [CH_W-1:0] word_chan;
    logic            frame_err;

    int n_chk = 0;
    int n_bad = 0;

    bit prev_exists = 1'b0;
    bit prev_mode   = 1'b0;
    int prev_fid    = 0;
    int prev_len    = 0;

    always #2 clk = ~clk;

    tdm_rx #(.CHANNELS(NCH)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .sdata      (sdata),
        .slot16     (slot16),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_chan  (word_chan),
        .frame_err  (frame_err)
    );

    // Expected word in output form (MSB-aligned, low byte zero in 16-bit mode).
    function automatic logic [23:0] word_of(int fid, int slot, bit m16);
        logic [23:0] w;
        w = 24'(fid * 32'h13579 + slot * 32'h2468B + 32'h0C3A5) | 24'h1;
        if (m16) begin
            return {w[15:0], 8'h00};
        end
        return w;
    endfunction

    function automatic int slot_len(bit m16);
        return m16 ? 16 : 32;
    endfunction

    function automatic int audio_len(bit m16);
        return m16 ? 16 : 24;
    endfunction

    // Serial bit at position p after the first data bit; pad and idle bits are ones.
    function automatic logic stream_bit(bit m16, int fid, int p);
        logic [23:0] w;
        int b;
        if (p / slot_len(m16) >= NCH) return 1'b1;
        b = p % slot_len(m16);
        if (b >= audio_len(m16)) return 1'b1;
        w = word_of(fid, p / slot_len(m16), m16);
        return w[23 - b];
    endfunction

    task automatic step(input logic fs, input logic d, input logic s16,
                        input logic ev, input logic [23:0] ed, input int ec,
                        input logic eerr, input string tag);
        @(negedge clk);
        fsync  = fs;
        sdata  = d;
        slot16 = s16;
        @(posedge clk);
        #1;
        n_chk++;
        if (word_valid !== ev || (ev && (word_data !== ed || word_chan !== CH_W'(ec)))) begin
            n_bad++;
            $display("FAIL %s: valid=%b data=%h chan=%0d expected valid=%b data=%h chan=%0d",
                     tag, word_valid, word_data, word_chan, ev, ed, ec);
        end
        n_chk++;
        if (frame_err !== eerr) begin
            n_bad++;
            $display("FAIL %s/R8: frame_err=%b expected %b", tag, frame_err, eerr);
        end
    endtask

    task automatic run_frame(input bit m16, input int flen, input int fsw,
                             input int fid, input bit tog, input string tag);
        for (int c = 0; c < flen; c++) begin
            logic        fs;
            logic        d;
            logic        s16;
            logic        ev;
            logic        eerr;
            logic [23:0] ed;
            int          ec;
            int          p;
            bit          pm;
            fs   = (c < fsw);
            s16  = (tog && c >= 2) ? ~m16 : m16;
            eerr = 1'b0;
            ev   = 1'b0;
            ed   = '0;
            ec   = 0;
            if (c == 0) begin
                if (prev_exists) begin
                    pm   = prev_mode;
                    p    = prev_len - 1;
                    d    = stream_bit(pm, prev_fid, p);
                    ev   = (p < NCH * slot_len(pm)) && (p % slot_len(pm) == audio_len(pm) - 1);
                    ed   = word_of(prev_fid, p / slot_len(pm), pm);
                    ec   = p / slot_len(pm);
                    eerr = (prev_len < NCH * slot_len(pm));
                end else begin
                    d = 1'b1;
                end
                step(fs, d, s16, ev, ed, ec, eerr, "R2/R7 frame start");
            end else begin
                p  = c - 1;
                d  = stream_bit(m16, fid, p);
                ev = (p < NCH * slot_len(m16)) && (p % slot_len(m16) == audio_len(m16) - 1);
                ed = word_of(fid, p / slot_len(m16), m16);
                ec = p / slot_len(m16);
                step(fs, d, s16, ev, ed, ec, eerr, tag);
            end
        end
        prev_exists = 1'b1;
        prev_mode   = m16;
        prev_fid    = fid;
        prev_len    = flen;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (word_valid !== 1'b0 || frame_err !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: valid=%b err=%b expected 0 0", word_valid, frame_err);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 24'h0, 0, 1'b0, "R1");

        // R2 R3 R7: 32-bit frames, exact length, narrow and wide markers
        run_frame(1'b0, 128, 1,  1, 1'b0, "R3");
        run_frame(1'b0, 128, 64, 2, 1'b0, "R2/R3");
        // R4 R7: 16-bit frames, last audio bit overlaps next marker
        run_frame(1'b1, 64,  1,  3, 1'b0, "R4");
        run_frame(1'b1, 64,  32, 4, 1'b0, "R4/R5");
        // R6: idle bits after the last slot
        run_frame(1'b1, 80,  3,  5, 1'b0, "R6");
        // R8: early marker inside a 32-bit frame
        run_frame(1'b0, 70,  2,  6, 1'b0, "R8");
        // R9: select toggles mid-frame
        run_frame(1'b0, 128, 1,  7, 1'b1, "R9");
        // R8: early marker inside a 16-bit frame
        run_frame(1'b1, 40,  1,  8, 1'b0, "R8");
        run_frame(1'b1, 64,  63, 9, 1'b1, "R9/R2");
        run_frame(1'b0, 140, 10, 10, 1'b0, "R6");

        // trailing idle: no words, no errors
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 24'h0, 0, 1'b0, "R6 idle");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule